// File: doc/BRIEF.md
# Descriptor Ring Table Controller

This block holds the buffer descriptors of a packet DMA engine and walks them for the engine. A bus slave with a single-cycle acknowledge gives software a small control space and a word-addressed descriptor table. One table is shared by a transmit ring and a receive ring. A count register splits the table between them: the transmit ring takes the low entries, and the receive ring starts at the first entry after it.

Each ring has its own walker state machine. A walker reads the current descriptor and waits while the ready bit is clear. When the bit is set, it latches the word and offers it to the DMA side with a valid level, an absolute index and the full word. It then waits for a done pulse that carries the length actually moved. On that pulse it writes the descriptor back with the ready bit cleared and the new length, and steps to the next entry. It returns to the ring base after an entry that has the wrap bit set, or after the last entry of its region.

A soft-reset bit in the mode register holds both walkers and sends their pointers back to the ring bases. Clearing the bit restarts both rings from entry zero.

The bus state machine has two states: B_IDLE and B_ACK. A request moves B_IDLE to B_ACK. The next cycle always moves B_ACK back to B_IDLE.

Each walker has four states: W_HOLD, W_LOOK, W_OFFER and W_RETIRE.
- W_HOLD moves to W_LOOK when the ring is not empty.
- W_LOOK moves to W_HOLD if the ring is empty. It moves to W_OFFER when the ready bit is set.
- W_OFFER moves to W_RETIRE on done.
- W_RETIRE moves to W_LOOK when the write-back is granted.
- Soft reset forces W_HOLD from any state.

Top module: `desc_table_ctrl`

## Requirements
- R1: Every bus request (cyc and stb high) is acknowledged exactly one cycle later, and ack is a one-cycle pulse.
- R2: With byte address bits [11:10] = 00, word 0 is the mode register and word 1 is the transmit entry count. Other control words read zero.
- R3: The transmit count resets to 64 (half of 128 entries). A write above 128 stores 128.
- R4: With address bits [11:10] = 01, the descriptor word index is address bits [9:2]. Indices 0..127 read and write the table. Indices 128..255 read zero and ignore writes. Addresses with bit 11 set read zero and ignore writes.
- R5: The transmit ring starts at index 0. A descriptor is offered only when its ready bit (bit 15) is set, and the walker stalls with valid low while that bit is clear.
- R6: The offered word is the descriptor as stored. Length is in [31:16], ready in 15, wrap in 13, the control-frame mark in 9, and the software tag in [7:0]. It stays stable while valid is high.
- R7: A done pulse during an offer rewrites that descriptor with [31:16] set to the reported length and bit 15 cleared, keeps bits [14:0] otherwise, and advances to the next index.
- R8: After an entry with bit 13 set, or after the last entry of its ring, a walker returns to the ring base.
- R9: Receive entry n sits at table index (transmit count + n). Its done pulse writes back the received length with ready cleared.
- R10: Setting mode bit 11 drops both valids within one cycle and holds the walkers. Clearing it restarts both rings at entry 0.
- R11: A done pulse while the ring offers nothing changes neither the table nor the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable |
| bus_adr | input | 10 | Word address (byte address bits [11:2]) |
| bus_wdat | input | 32 | Write data |
| bus_ack | output | 1 | Acknowledge pulse |
| bus_rdat | output | 32 | Read data, valid with ack |
| tx_desc_valid | output | 1 | Transmit descriptor offered |
| tx_desc_index | output | 8 | Absolute table index of offered transmit entry |
| tx_desc_word | output | 32 | Offered transmit descriptor |
| tx_done | input | 1 | Transmit entry finished |
| tx_done_len | input | 16 | Length to write back for transmit |
| rx_desc_valid | output | 1 | Receive descriptor offered |
| rx_desc_index | output | 8 | Absolute table index of offered receive entry |
| rx_desc_word | output | 32 | Offered receive descriptor |
| rx_done | input | 1 | Receive entry finished |
| rx_done_len | input | 16 | Received length to write back |

## Verification
The bench targets several corner cases:
- A ready bit that is clear. A walker that skipped it would offer stale entries.
- Both ring-return paths: the wrap bit, and the end of a shortened region. A walker missing either would step past its ring into the neighbour's entries.
- A receive base that moves with the count register. A fixed base would offer the wrong index after the split changes.
- A stray done pulse while idle. An unguarded walker would corrupt a descriptor.
- Soft reset in the middle of an offer. A walker that kept its pointer would resume mid-ring instead of at entry 0.
- Count saturation, and out-of-table addresses that must read zero.

// File: rtl/desc_table_pkg.sv
package desc_table_pkg;
    localparam int LEN_LSB  = 16;
    localparam int RDY_BIT  = 15;
    localparam int WRAP_BIT = 13;
    localparam int CTRL_BIT = 9;
    localparam int SRST_BIT = 11;

    localparam logic [1:0] REG_SPACE = 2'b00;
    localparam logic [1:0] BD_SPACE  = 2'b01;

    typedef enum logic [1:0] {
        W_HOLD,
        W_LOOK,
        W_OFFER,
        W_RETIRE
    } walk_state_t;

    typedef enum logic {
        B_IDLE,
        B_ACK
    } bus_state_t;
endpackage

// File: rtl/dt_bus_slave.sv
module dt_bus_slave
    import desc_table_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 128,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int CNT_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:2] bus_adr,
    input  logic [DATA_W-1:0] bus_wdat,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdat,
    output logic              srst,
    output logic [CNT_W-1:0]  tx_count,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WORD_W = ADDR_W - 4;
    localparam logic [WORD_W:0]   TABLE_END  = (WORD_W + 1)'(DEPTH);
    localparam logic [CNT_W-1:0]  CNT_MAX    = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0]  CNT_INIT   = CNT_W'(DEPTH / 2);
    localparam logic [DATA_W-1:0] CNT_LIMIT  = DATA_W'(DEPTH);
    localparam logic [WORD_W-1:0] WORD_MODE  = WORD_W'(0);
    localparam logic [WORD_W-1:0] WORD_COUNT = WORD_W'(1);

    bus_state_t        state, state_nx;
    logic [1:0]        region;
    logic [WORD_W-1:0] word;
    logic              in_table;
    logic              req;
    logic              srst_q;
    logic [CNT_W-1:0]  count_q;
    logic [DATA_W-1:0] rd_sel;
    logic [DATA_W-1:0] rdat_q;

    assign region   = bus_adr[ADDR_W-1 -: 2];
    assign word     = bus_adr[ADDR_W-3:2];
    assign in_table = ({1'b0, word} < TABLE_END);
    assign req      = (state == B_IDLE) && bus_cyc && bus_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= B_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            B_IDLE: if (bus_cyc && bus_stb) state_nx = B_ACK;
            B_ACK:  state_nx = B_IDLE;
        endcase
    end

    always_comb begin
        bus_ack  = (state == B_ACK);
        bus_rdat = rdat_q;
        srst     = srst_q;
        tx_count = count_q;
    end

    assign mem_we    = req && bus_we && (region == BD_SPACE) && in_table;
    assign mem_addr  = word[IDX_W-1:0];
    assign mem_wdata = bus_wdat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_q  <= 1'b0;
            count_q <= CNT_INIT;
        end else if (req && bus_we && (region == REG_SPACE)) begin
            if (word == WORD_MODE)
                srst_q <= bus_wdat[SRST_BIT];
            else if (word == WORD_COUNT)
                count_q <= (bus_wdat > CNT_LIMIT) ? CNT_MAX : bus_wdat[CNT_W-1:0];
        end
    end

    always_comb begin
        rd_sel = '0;
        unique case (region)
            REG_SPACE: begin
                if (word == WORD_MODE)       rd_sel[SRST_BIT] = srst_q;
                else if (word == WORD_COUNT) rd_sel = DATA_W'(count_q);
            end
            BD_SPACE: if (in_table) rd_sel = mem_rdata;
            default: rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   rdat_q <= '0;
        else if (req) rdat_q <= rd_sel;
    end

    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    p_ack_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_cyc && bus_stb));
    p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_MAX);
endmodule

// File: rtl/dt_desc_mem.sv
module dt_desc_mem #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  tx_raddr,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic [IDX_W-1:0]  rx_raddr,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              tx_wb_req,
    input  logic [IDX_W-1:0]  tx_wb_addr,
    input  logic [DATA_W-1:0] tx_wb_data,
    output logic              tx_wb_grant,
    input  logic              rx_wb_req,
    input  logic [IDX_W-1:0]  rx_wb_addr,
    input  logic [DATA_W-1:0] rx_wb_data,
    output logic              rx_wb_grant
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_en;
    logic [IDX_W-1:0]  wr_addr;
    logic [DATA_W-1:0] wr_data;

    // Software writes win; transmit write-back beats receive write-back.
    always_comb begin
        tx_wb_grant = tx_wb_req && !bus_we;
        rx_wb_grant = rx_wb_req && !bus_we && !tx_wb_req;
        wr_en   = bus_we || tx_wb_grant || rx_wb_grant;
        wr_addr = bus_we ? bus_addr  : (tx_wb_grant ? tx_wb_addr : rx_wb_addr);
        wr_data = bus_we ? bus_wdata : (tx_wb_grant ? tx_wb_data : rx_wb_data);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && (wr_addr == IDX_W'(g)))
                mem[g] <= wr_data;
        end
    end

    assign bus_rdata = mem[bus_addr];
    assign tx_rdata  = mem[tx_raddr];
    assign rx_rdata  = mem[rx_raddr];
endmodule

// File: rtl/dt_ring_walker.sv
module dt_ring_walker
    import desc_table_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 7,
    parameter int CNT_W  = IDX_W + 1,
    parameter int LEN_W  = DATA_W - LEN_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic [CNT_W-1:0]  ring_base,
    input  logic [CNT_W-1:0]  ring_len,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              desc_valid,
    output logic [CNT_W-1:0]  desc_index,
    output logic [DATA_W-1:0] desc_word,
    input  logic              done,
    input  logic [LEN_W-1:0]  done_len,
    output logic              wb_req,
    output logic [IDX_W-1:0]  wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_grant
);
    walk_state_t       state, state_nx;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  idx_inc;
    logic [CNT_W-1:0]  idx_next;
    logic [CNT_W-1:0]  abs_idx;
    logic [DATA_W-1:0] desc_q;
    logic [LEN_W-1:0]  len_q;
    logic              ring_empty;
    logic              idx_out;

    assign ring_empty = (ring_len == '0);
    assign idx_out    = (idx >= ring_len);
    assign abs_idx    = ring_base + idx;
    assign idx_inc    = idx + CNT_W'(1);
    assign idx_next   = (desc_q[WRAP_BIT] || (idx_inc >= ring_len)) ? '0 : idx_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= W_HOLD;
        else if (srst) state <= W_HOLD;
        else           state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            W_HOLD:   if (!ring_empty) state_nx = W_LOOK;
            W_LOOK: begin
                if (ring_empty)                       state_nx = W_HOLD;
                else if (!idx_out && rd_data[RDY_BIT]) state_nx = W_OFFER;
            end
            W_OFFER:  if (done)     state_nx = W_RETIRE;
            W_RETIRE: if (wb_grant) state_nx = W_LOOK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            desc_q <= '0;
            len_q  <= '0;
        end else if (srst) begin
            idx <= '0;
        end else begin
            unique case (state)
                W_HOLD: ;
                W_LOOK: begin
                    if (idx_out)                   idx    <= '0;
                    else if (rd_data[RDY_BIT])     desc_q <= rd_data;
                end
                W_OFFER:  if (done)     len_q <= done_len;
                W_RETIRE: if (wb_grant) idx   <= idx_next;
            endcase
        end
    end

    always_comb begin
        rd_addr    = abs_idx[IDX_W-1:0];
        wb_addr    = abs_idx[IDX_W-1:0];
        desc_valid = (state == W_OFFER);
        desc_index = abs_idx;
        desc_word  = desc_q;
        wb_req     = (state == W_RETIRE);
        wb_data    = {len_q, 1'b0, desc_q[RDY_BIT-1:0]};
    end

    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && state == W_LOOK && !ring_empty && !idx_out && !rd_data[RDY_BIT])
        |=> (state == W_LOOK) && $stable(idx));
    p_offer_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && state == W_OFFER && !done) |=> desc_valid && $stable(desc_word));
    p_wrap_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && state == W_RETIRE && wb_grant && desc_q[WRAP_BIT]) |=> (idx == '0));
    p_srst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !desc_valid && (idx == '0));
endmodule

// File: rtl/desc_table_ctrl.sv
module desc_table_ctrl
    import desc_table_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 128,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int CNT_W  = IDX_W + 1,
    parameter int LEN_W  = DATA_W - LEN_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:2] bus_adr,
    input  logic [DATA_W-1:0] bus_wdat,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdat,
    output logic              tx_desc_valid,
    output logic [CNT_W-1:0]  tx_desc_index,
    output logic [DATA_W-1:0] tx_desc_word,
    input  logic              tx_done,
    input  logic [LEN_W-1:0]  tx_done_len,
    output logic              rx_desc_valid,
    output logic [CNT_W-1:0]  rx_desc_index,
    output logic [DATA_W-1:0] rx_desc_word,
    input  logic              rx_done,
    input  logic [LEN_W-1:0]  rx_done_len
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic              srst;
    logic [CNT_W-1:0]  tx_count;
    logic [CNT_W-1:0]  rx_len;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [IDX_W-1:0]  tx_raddr, rx_raddr, tx_wb_addr, rx_wb_addr;
    logic [DATA_W-1:0] tx_rdata, rx_rdata, tx_wb_data, rx_wb_data;
    logic              tx_wb_req, rx_wb_req, tx_wb_grant, rx_wb_grant;

    assign rx_len = CNT_MAX - tx_count;

    dt_bus_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_wdat(bus_wdat),
        .bus_ack(bus_ack), .bus_rdat(bus_rdat),
        .srst(srst), .tx_count(tx_count),
        .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    dt_desc_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .bus_we(mem_we), .bus_addr(mem_addr), .bus_wdata(mem_wdata), .bus_rdata(mem_rdata),
        .tx_raddr(tx_raddr), .tx_rdata(tx_rdata),
        .rx_raddr(rx_raddr), .rx_rdata(rx_rdata),
        .tx_wb_req(tx_wb_req), .tx_wb_addr(tx_wb_addr), .tx_wb_data(tx_wb_data),
        .tx_wb_grant(tx_wb_grant),
        .rx_wb_req(rx_wb_req), .rx_wb_addr(rx_wb_addr), .rx_wb_data(rx_wb_data),
        .rx_wb_grant(rx_wb_grant)
    );

    dt_ring_walker #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_tx_walk (
        .clk(clk), .rst_n(rst_n), .srst(srst),
        .ring_base('0), .ring_len(tx_count),
        .rd_addr(tx_raddr), .rd_data(tx_rdata),
        .desc_valid(tx_desc_valid), .desc_index(tx_desc_index), .desc_word(tx_desc_word),
        .done(tx_done), .done_len(tx_done_len),
        .wb_req(tx_wb_req), .wb_addr(tx_wb_addr), .wb_data(tx_wb_data), .wb_grant(tx_wb_grant)
    );

    dt_ring_walker #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_rx_walk (
        .clk(clk), .rst_n(rst_n), .srst(srst),
        .ring_base(tx_count), .ring_len(rx_len),
        .rd_addr(rx_raddr), .rd_data(rx_rdata),
        .desc_valid(rx_desc_valid), .desc_index(rx_desc_index), .desc_word(rx_desc_word),
        .done(rx_done), .done_len(rx_done_len),
        .wb_req(rx_wb_req), .wb_addr(rx_wb_addr), .wb_data(rx_wb_data), .wb_grant(rx_wb_grant)
    );

    // R9: a receive offer always lies at or above the split point.
    p_rx_above_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_desc_valid |-> (rx_desc_index >= tx_count));
endmodule

// File: tb/desc_table_ctrl_bench.sv
module desc_table_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
    logic [11:2] bus_adr = '0;
    logic [31:0] bus_wdat = '0;
    logic        bus_ack;
    logic [31:0] bus_rdat;
    logic        tx_desc_valid, rx_desc_valid;
    logic [7:0]  tx_desc_index, rx_desc_index;
    logic [31:0] tx_desc_word, rx_desc_word;
    logic        tx_done = 1'b0, rx_done = 1'b0;
    logic [15:0] tx_done_len = '0, rx_done_len = '0;

    int checks = 0;
    int errors = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    desc_table_ctrl u_desc_table_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_wdat(bus_wdat),
        .bus_ack(bus_ack), .bus_rdat(bus_rdat),
        .tx_desc_valid(tx_desc_valid), .tx_desc_index(tx_desc_index),
        .tx_desc_word(tx_desc_word), .tx_done(tx_done), .tx_done_len(tx_done_len),
        .rx_desc_valid(rx_desc_valid), .rx_desc_index(rx_desc_index),
        .rx_desc_word(rx_desc_word), .rx_done(rx_done), .rx_done_len(rx_done_len)
    );

    typedef struct packed {
        logic        we;
        logic [11:0] adr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 12'h004, 32'h0,        32'h0000_0040, 4'd3},  // R3 reset count
        '{1'b0, 12'h000, 32'h0,        32'h0000_0000, 4'd2},  // R2 mode at reset
        '{1'b1, 12'h004, 32'h200,      32'h0,         4'd3},
        '{1'b0, 12'h004, 32'h0,        32'h0000_0080, 4'd3},  // R3 saturation
        '{1'b1, 12'h004, 32'h10,       32'h0,         4'd2},
        '{1'b0, 12'h004, 32'h0,        32'h0000_0010, 4'd2},  // R2 count readback
        '{1'b1, 12'h000, 32'hffff_ffff,32'h0,         4'd10},
        '{1'b0, 12'h000, 32'h0,        32'h0000_0800, 4'd10}, // R10 only bit 11 kept
        '{1'b1, 12'h000, 32'h0,        32'h0,         4'd10},
        '{1'b0, 12'h000, 32'h0,        32'h0000_0000, 4'd10}, // R10 released
        '{1'b1, 12'h400, 32'h1234_0055,32'h0,         4'd4},
        '{1'b0, 12'h400, 32'h0,        32'h1234_0055, 4'd4},  // R4 table word 0
        '{1'b1, 12'h7FC, 32'hdead_beef,32'h0,         4'd4},
        '{1'b0, 12'h7FC, 32'h0,        32'h0000_0000, 4'd4},  // R4 index 255 outside
        '{1'b1, 12'h800, 32'hffff_ffff,32'h0,         4'd4},
        '{1'b0, 12'h800, 32'h0,        32'h0000_0000, 4'd4},  // R4 bit 11 set
        '{1'b1, 12'h5FC, 32'h0000_00aa,32'h0,         4'd4},
        '{1'b0, 12'h5FC, 32'h0,        32'h0000_00aa, 4'd4},  // R4 index 127
        '{1'b0, 12'h008, 32'h0,        32'h0000_0000, 4'd2}   // R2 unused control word
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic w, input logic [11:0] a, input logic [31:0] d,
                            output logic [31:0] q);
        int n;
        n = 0;
        @(negedge clk);
        bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = w; bus_adr = a[11:2]; bus_wdat = d;
        do begin
            @(negedge clk);
            n++;
        end while (!bus_ack && n < 20);
        chk(bus_ack === 1'b1 && n == 1, "R1", 32'(n), 32'd1);
        q = bus_rdat;
        bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus_xfer(1'b1, a, d, q);
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] q;
        bus_xfer(1'b0, a, 32'h0, q);
        chk(q === exp, tag, q, exp);
    endtask

    task automatic wait_tx(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 8 && !seen; i++) begin
            @(negedge clk);
            if (tx_desc_valid) seen = 1'b1;
        end
    endtask

    task automatic wait_rx(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 8 && !seen; i++) begin
            @(negedge clk);
            if (rx_desc_valid) seen = 1'b1;
        end
    endtask

    task automatic expect_tx(input logic [7:0] idx, input logic [31:0] word, input string tag);
        bit seen;
        wait_tx(seen);
        chk(seen, tag, 32'(tx_desc_valid), 32'd1);
        chk(tx_desc_index === idx, tag, 32'(tx_desc_index), 32'(idx));
        chk(tx_desc_word === word, tag, tx_desc_word, word);
    endtask

    task automatic tx_finish(input logic [15:0] len);
        @(negedge clk); tx_done = 1'b1; tx_done_len = len;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic rx_finish(input logic [15:0] len);
        @(negedge clk); rx_done = 1'b1; rx_done_len = len;
        @(negedge clk); rx_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R5: quiet outputs after reset
        chk(bus_ack === 1'b0, "R1", 32'(bus_ack), 32'd0);
        chk(tx_desc_valid === 1'b0, "R5", 32'(tx_desc_valid), 32'd0);
        chk(rx_desc_valid === 1'b0, "R9", 32'(rx_desc_valid), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].we) wr(VECS[i].adr, VECS[i].wd);
            else rd_chk(VECS[i].adr, VECS[i].exp, $sformatf("R%0d", VECS[i].req));
        end

        // R5: entry 0 not ready -> stall
        repeat (6) @(negedge clk);
        chk(tx_desc_valid === 1'b0, "R5", 32'(tx_desc_valid), 32'd0);

        // R5 R6: ready, control-frame mark, tag
        wr(12'h400, 32'h0064_8211);
        expect_tx(8'd0, 32'h0064_8211, "R6");

        // R11: stray receive done while receive ring idle
        rx_finish(16'h1234);
        rd_chk(12'h440, 32'h0, "R11");
        chk(rx_desc_valid === 1'b0, "R11", 32'(rx_desc_valid), 32'd0);

        // R7: write-back and advance
        tx_finish(16'h005C);
        rd_chk(12'h400, 32'h005C_0211, "R7");
        repeat (3) @(negedge clk);
        chk(tx_desc_valid === 1'b0, "R7", 32'(tx_desc_valid), 32'd0);
        wr(12'h404, 32'h0020_A022);
        expect_tx(8'd1, 32'h0020_A022, "R7");
        tx_finish(16'h0020);

        // R8: wrap bit returns to base
        wr(12'h400, 32'h0010_8033);
        expect_tx(8'd0, 32'h0010_8033, "R8");
        tx_finish(16'h0010);

        // R9: receive ring starts at index 16 (count = 16)
        wr(12'h440, 32'h0040_8044);
        wait_rx(seen);
        chk(seen, "R9", 32'(rx_desc_valid), 32'd1);
        chk(rx_desc_index === 8'h10, "R9", 32'(rx_desc_index), 32'h10);
        chk(rx_desc_word === 32'h0040_8044, "R9", rx_desc_word, 32'h0040_8044);
        rx_finish(16'h002A);
        rd_chk(12'h440, 32'h002A_0044, "R9");

        // R10: soft reset in the middle of an offer
        wr(12'h404, 32'h0009_8002);
        expect_tx(8'd1, 32'h0009_8002, "R10");
        wr(12'h000, 32'h0000_0800);
        @(negedge clk);
        chk(tx_desc_valid === 1'b0, "R10", 32'(tx_desc_valid), 32'd0);
        wr(12'h004, 32'h2);
        wr(12'h400, 32'h0008_8001);
        repeat (3) @(negedge clk);
        chk(tx_desc_valid === 1'b0, "R10", 32'(tx_desc_valid), 32'd0);
        wr(12'h000, 32'h0);
        expect_tx(8'd0, 32'h0008_8001, "R10");
        tx_finish(16'h0008);
        expect_tx(8'd1, 32'h0009_8002, "R7");
        tx_finish(16'h0009);

        // R8: end of a two-entry ring returns to base without wrap bit
        wr(12'h400, 32'h0007_8003);
        expect_tx(8'd0, 32'h0007_8003, "R8");
        tx_finish(16'h0007);

        // R9: receive base follows the new count (2)
        wr(12'h408, 32'h0030_8055);
        wait_rx(seen);
        chk(seen, "R9", 32'(rx_desc_valid), 32'd1);
        chk(rx_desc_index === 8'h02, "R9", 32'(rx_desc_index), 32'h02);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule